// File: doc/BRIEF.md
# Instruction Fetch and Next-PC Unit

This block sits at the front of a single-cycle processor. It holds the program counter and reads an instruction word from a small internal instruction store. The read is combinational and uses the current counter. On every rising clock edge it loads the counter with the next address. That address is the sequential step of four bytes, a taken relative branch, or an absolute jump.

The relative branch is taken only when the decoder asks for one and the datapath reports that its two operands are equal. A jump overrides both other paths. The branch offset and the jump target field come from the fetched word itself, so the block needs no immediate from outside.

The instruction store is filled through a one-word synchronous load port. The enclosing system uses it to place a program before or while the core runs.

Top module: `instr_fetch_unit`

## Requirements
- R1: When `rst` is 1 at a rising edge, `pc` becomes 0 at that edge, whatever `jump`, `branchSel` and `equal` are.
- R2: `instr` always equals the stored word at index `pc[IDX_W+1:2]` within the same cycle, with no clock edge in between.
- R3: With `jump` 0 and `branchSel` 0 and `equal` 0, `pc` steps to `pc + 4` at the edge.
- R4: With `jump` 0, `branchSel` 1 and `equal` 1, `pc` becomes `pc + 4 + (sext(imm) << 2)` at the edge.
- R5: When exactly one of `branchSel` and `equal` is 1 and `jump` is 0, `pc` still becomes `pc + 4`.
- R6: With `jump` 1, `pc` becomes `{pc[31:28], tgt, 2'b00}`, using the current `pc`. This holds whatever `branchSel` and `equal` are.
- R7: The branch offset `imm` is `instr[15:0]`, sign-extended from bit 15. The jump field `tgt` is `instr[25:0]`. All address arithmetic wraps modulo 2^32.
- R8: A load (`loadEn` 1) writes `loadData` at index `loadAddr` on the rising edge. The word is visible on `instr` from the next cycle, and the load does not change how `pc` advances.
- R9: `pc[1:0]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| loadEn | input | 1 | Write strobe for the instruction store |
| loadAddr | input | IDX_W | Word index written by a load |
| loadData | input | 32 | Word written by a load |
| branchSel | input | 1 | Decoder marks the current word as a conditional branch |
| equal | input | 1 | Operand-equality flag from the datapath |
| jump | input | 1 | Decoder marks the current word as an absolute jump |
| instr | output | 32 | Word fetched at the current counter |
| pc | output | 32 | Current program counter |

## Verification
A wrong counter shows on `pc` at the first edge after the mistake. From then on it also shows on `instr`, because every later fetch reads from the wrong word. The bench therefore compares both ports after every edge, under all eight combinations of the three select inputs. It also drives a large negative branch so that the counter wraps into its top nibble, and then a jump from there, which shows whether the upper four bits come from the current counter. A load into the word about to be fetched must show on `instr` one cycle later and must leave the `pc` sequence as it was.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int ADDR_W = 32;
  localparam int IMM_W  = 16;
  localparam int TGT_W  = 26;
  localparam int REGION_W = ADDR_W - TGT_W - 2;
  localparam logic [ADDR_W-1:0] STEP_BYTES = 32'd4;
  localparam logic [ADDR_W-1:0] RESET_PC   = 32'd0;

  typedef struct packed {
    logic takeBranch;
    logic takeJump;
  } pcSelStrobe_t;
endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
(
  input  logic         branchSel,
  input  logic         equal,
  input  logic         jump,
  output pcSelStrobe_t strobe
);
  always_comb begin
    strobe.takeJump   = jump;
    strobe.takeBranch = branchSel & equal & ~jump;
  end
endmodule

// File: rtl/fetch_imem.sv
module fetch_imem #(
  parameter int WORDS  = 64,
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [WORD_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [WORD_W-1:0] rdData
);
  logic [WORD_W-1:0] store [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (wrEn && wrIdx == IDX_W'(w)) begin
        store[w] <= wrData;
      end
    end
  end

  assign rdData = store[rdIdx];
endmodule

// File: rtl/fetch_datapath.sv
module fetch_datapath
  import fetch_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  pcSelStrobe_t       strobe,
  input  logic [TGT_W-1:0]   tgtField,
  output logic [ADDR_W-1:0]  pc
);
  logic [IMM_W-1:0]  immField;
  logic [ADDR_W-1:0] seqPc;
  logic [ADDR_W-1:0] brOffset;
  logic [ADDR_W-1:0] brPc;
  logic [ADDR_W-1:0] jmpPc;
  logic [ADDR_W-1:0] nextPc;

  assign immField = tgtField[IMM_W-1:0];

  // dedicated adders, kept apart from any ALU
  assign seqPc    = pc + STEP_BYTES;
  assign brOffset = {{(ADDR_W-IMM_W-2){immField[IMM_W-1]}}, immField, 2'b00};
  assign brPc     = seqPc + brOffset;
  assign jmpPc    = {pc[ADDR_W-1 -: REGION_W], tgtField, 2'b00};

  always_comb begin
    nextPc = seqPc;
    if (strobe.takeBranch) nextPc = brPc;
    if (strobe.takeJump)   nextPc = jmpPc;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= RESET_PC;
    else     pc <= nextPc;
  end
endmodule

// File: rtl/instr_fetch_unit.sv
module instr_fetch_unit
  import fetch_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  localparam int IDX_W = $clog2(IMEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  logic [IDX_W-1:0]  loadAddr,
  input  logic [31:0]       loadData,
  input  logic              branchSel,
  input  logic              equal,
  input  logic              jump,
  output logic [31:0]       instr,
  output logic [31:0]       pc
);
  pcSelStrobe_t strobe;

  fetch_ctrl u_ctrl (
    .branchSel(branchSel),
    .equal    (equal),
    .jump     (jump),
    .strobe   (strobe)
  );

  fetch_imem #(.WORDS(IMEM_WORDS), .WORD_W(32)) u_imem (
    .clk   (clk),
    .wrEn  (loadEn),
    .wrIdx (loadAddr),
    .wrData(loadData),
    .rdIdx (pc[IDX_W+1:2]),
    .rdData(instr)
  );

  fetch_datapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .tgtField(instr[TGT_W-1:0]),
    .pc      (pc)
  );
endmodule

// File: rtl/instr_fetch_chk.sv
module instr_fetch_chk (
  input logic        clk,
  input logic        rst,
  input logic        branchSel,
  input logic        equal,
  input logic        jump,
  input logic [31:0] instr,
  input logic [31:0] pc
);
  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> pc == 32'd0);

  // R3
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!jump && !branchSel && !equal) |=> pc == $past(pc) + 32'd4);

  // R5
  half_cond_chk: assert property (@(posedge clk) disable iff (rst)
    (!jump && (branchSel != equal)) |=> pc == $past(pc) + 32'd4);

  // R4
  branch_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (!jump && branchSel && equal) |=>
      pc == $past(pc) + 32'd4 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});

  // R6
  jump_target_chk: assert property (@(posedge clk) disable iff (rst)
    jump |=> pc == {$past(pc[31:28]), $past(instr[25:0]), 2'b00});

  // R9
  pc_align_chk: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);
endmodule

bind instr_fetch_unit instr_fetch_chk u_chk (
  .clk(clk), .rst(rst), .branchSel(branchSel), .equal(equal),
  .jump(jump), .instr(instr), .pc(pc)
);

// File: tb/sim_instr_fetch_unit.sv
module sim_instr_fetch_unit;
  localparam int WORDS = 64;
  localparam int IDX_W = $clog2(WORDS);
  localparam int NVEC  = 16;
  // each entry: {branchSel, equal, jump}
  localparam logic [2:0] VEC [NVEC] = '{
    3'b000, 3'b110, 3'b000, 3'b100, 3'b010, 3'b001, 3'b110, 3'b111,
    3'b000, 3'b101, 3'b011, 3'b110, 3'b100, 3'b000, 3'b001, 3'b010
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic loadEn = 1'b0;
  logic [IDX_W-1:0] loadAddr = '0;
  logic [31:0] loadData = '0;
  logic branchSel = 1'b0, equal = 1'b0, jump = 1'b0;
  logic [31:0] instr, pc;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] model [WORDS];
  logic [31:0] modelPc;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  instr_fetch_unit #(.IMEM_WORDS(WORDS)) u0 (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadAddr(loadAddr),
    .loadData(loadData), .branchSel(branchSel), .equal(equal),
    .jump(jump), .instr(instr), .pc(pc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] calcNext(input logic [31:0] p, input logic [31:0] w,
                                           input logic bs, input logic eq, input logic jp);
    if (jp) return {p[31:28], w[25:0], 2'b00};
    if (bs && eq) return p + 32'd4 + {{14{w[15]}}, w[15:0], 2'b00};
    return p + 32'd4;
  endfunction

  function automatic string tagFor(input logic bs, input logic eq, input logic jp);
    if (jp) return "R6";
    if (bs && eq) return "R4";
    if (bs || eq) return "R5";
    return "R3";
  endfunction

  // one clock step; inputs driven just after a falling edge, checks at the next one
  task automatic step(input logic bs, input logic eq, input logic jp, input logic ld,
                      input logic [IDX_W-1:0] la, input logic [31:0] ldat, input string req);
    logic [31:0] w;
    w = model[modelPc[IDX_W+1:2]];
    branchSel = bs; equal = eq; jump = jp;
    loadEn = ld; loadAddr = la; loadData = ldat;
    if (rst) modelPc = 32'd0;
    else     modelPc = calcNext(modelPc, w, bs, eq, jp);
    if (ld) model[la] = ldat;
    @(posedge clk);
    @(negedge clk);
    loadEn = 1'b0;
    check(req, pc, modelPc);
    check("R9", {30'd0, pc[1:0]}, 32'd0);
    check("R2", instr, model[modelPc[IDX_W+1:2]]);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    modelPc = 32'd0;
    @(negedge clk);
    // fill the store during reset
    for (int i = 0; i < WORDS; i++) begin
      step(1'b0, 1'b0, 1'b1, 1'b1, IDX_W'(i), 32'(i) * 32'h9E3779B1 + 32'h0001_3579, "R1");
    end
    rst = 1'b0;
    check("R1", pc, 32'd0);
    check("R2", instr, model[0]);

    // vector table, several passes
    for (int pass = 0; pass < 3; pass++) begin
      for (int v = 0; v < NVEC; v++) begin
        step(VEC[v][2], VEC[v][1], VEC[v][0], 1'b0, '0, '0,
             tagFor(VEC[v][2], VEC[v][1], VEC[v][0]));
      end
    end

    // R8: load the word about to be fetched; it must appear next cycle, pc steps +4
    begin
      logic [31:0] np;
      np = modelPc + 32'd4;
      step(1'b0, 1'b0, 1'b0, 1'b1, np[IDX_W+1:2], 32'hCAFE_0123, "R8");
      check("R8", instr, 32'hCAFE_0123);
    end

    // R1: reset overrides jump and a taken branch
    rst = 1'b1;
    step(1'b1, 1'b1, 1'b1, 1'b1, IDX_W'(0), 32'h1000_8000, "R1");
    step(1'b0, 1'b0, 1'b1, 1'b1, IDX_W'(1), 32'h0A5A_5A5C, "R1");
    rst = 1'b0;
    check("R1", pc, 32'd0);

    // R7: imm 0x8000 sign-extends; counter wraps to 0xFFFE0004
    step(1'b1, 1'b1, 1'b0, 1'b0, '0, '0, "R7");
    check("R7", pc, 32'hFFFE_0004);
    // R6: jump keeps the current top nibble 0xF
    step(1'b0, 1'b1, 1'b1, 1'b0, '0, '0, "R6");
    check("R6", pc, {4'hF, 26'h25A_5A5C, 2'b00});
    step(1'b1, 1'b0, 1'b0, 1'b0, '0, '0, "R5");
    step(1'b0, 1'b0, 1'b0, 1'b0, '0, '0, "R3");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule